// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single output compare channel that sits beside a general-purpose timer counter. Each clock it receives the counter value, the counting direction and a one-cycle update pulse from the counter. From these and its own configuration it builds a registered reference level, active high, and a pin level that is the reference with an output polarity applied.

The channel keeps an active compare value. Writes reach it either directly or through a shadow copy that is moved across on the next update pulse. A 3-bit mode selects one of eight behaviours: hold, three exact-match actions, two forced levels and two pulse-width modes whose level depends on the counting direction. An external trigger, when enabled, pulls the reference low. A two-bit protection level can freeze the mode field against writes.

In the pulse-width modes the reference only moves in two cases: the mode has just come out of hold, or the raw compare result has changed. A trigger clear therefore persists until the next change in the compare result.

Top module: `tmr_cmp_channel`

## Requirements
- R1: Mode 3'b000 (hold) keeps the reference unchanged whatever the counter does.
- R2: Mode 3'b001 drives the reference to 1, and mode 3'b010 drives it to 0, in the clock after the counter arrives at the active compare value. An arrival means the values are equal in this cycle and were not equal in the previous cycle.
- R3: Mode 3'b011 inverts the reference once per arrival at the compare value. It does not invert again while the counter stays on that value.
- R4: Mode 3'b100 drives the reference to 0 and mode 3'b101 drives it to 1 on every clock.
- R5: Mode 3'b110: counting up (direction 0), the reference is 1 when counter < compare and 0 otherwise. Counting down (direction 1), it is 0 when counter > compare and 1 otherwise.
- R6: Mode 3'b111 gives the inverse of R5 in both directions.
- R7: In modes 3'b110 and 3'b111 the reference changes only in two cases: the previous cycle's mode was 3'b000, or the raw compare result (the level that mode 3'b110 would give) differs from the previous cycle's result. Switching from another mode, or between the two modes, with an unchanged result leaves the reference as it was.
- R8: When the clear enable is 1 and the trigger input is 1, the reference becomes 0 in the next clock in every mode, including 3'b101. With the clear enable at 0 the trigger has no effect.
- R9: With shadow enable at 1, a compare write goes to the shadow copy only. The shadow copy is moved into the active compare value at an update pulse.
- R10: With shadow enable at 0, a compare write updates the active compare value at the next clock, and update pulses do not change it.
- R11: The pin output equals the reference XOR the polarity input, combinationally.
- R12: While the protection level is 2'b11, mode writes are ignored. At any other level they take effect at the next clock.
- R13: Reset (synchronous, active low) sets the reference, the active compare value and the shadow copy to 0 and the mode to hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_val | input | CNT_W | Timer counter value |
| cnt_down | input | 1 | Counting direction, 0 = up, 1 = down |
| upd_evt | input | 1 | Update event pulse from the counter |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value write data |
| shadow_en | input | 1 | 1 = compare writes are held until the update event |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Mode write data |
| prot_lvl | input | 2 | Protection level; 2'b11 locks the mode |
| clr_en | input | 1 | Enables clearing of the reference by the trigger |
| ext_trig | input | 1 | External trigger level |
| polarity | input | 1 | 1 inverts the pin relative to the reference |
| ref_o | output | 1 | Reference level, active high |
| pin_o | output | 1 | Pin level after polarity |

## Verification
The bench builds the channel with CNT_W = 4. At that width both pulse-width modes can be swept over every counter value against every compare value, in both directions, with each expected level worked out from the comparison. The narrow width also lets the match-driven modes run the whole counter range at compare values 0, 6 and 15, with each value held for two cycles so that stalls on the match are covered. Further directed sequences cover the pulse-width hold rule, the trigger clear, the shadow path, the mode lock and reset.

// File: rtl/tcc_pkg.sv
// Shared types for the timer output compare channel.
// Assumes nothing beyond a 3-bit mode field and a 2-bit protection level.
package tcc_pkg;

    typedef enum logic [2:0] {
        MD_HOLD  = 3'b000,
        MD_SET   = 3'b001,
        MD_CLR   = 3'b010,
        MD_TGL   = 3'b011,
        MD_LOW   = 3'b100,
        MD_HIGH  = 3'b101,
        MD_PWM_A = 3'b110,
        MD_PWM_B = 3'b111
    } cmp_mode_e;

    localparam logic [1:0] LOCK_FULL = 2'b11;

endpackage

// File: rtl/tcc_cmp_store.sv
// Compare value storage: an active register plus an optional shadow copy.
// Assumes upd_evt is a single-cycle pulse. When shadow_en is 1, writes land in
// the shadow and move to the active value on upd_evt. When it is 0, writes
// land directly in the active value.
module tcc_cmp_store #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             shadow_en,
    input  logic             upd_evt,
    output logic [CNT_W-1:0] cmp_act
);

    logic [CNT_W-1:0] shadow_q;

    // Shadow copy captures writes only while shadowing is on.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (wr && shadow_en)
            shadow_q <= wdata;
    end

    // Active value: direct write, or transfer from the shadow on update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_act <= '0;
        else if (wr && !shadow_en)
            cmp_act <= wdata;
        else if (upd_evt && shadow_en)
            cmp_act <= shadow_q;
    end

    a_r9_shadow_load: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_evt && shadow_en) |=> (cmp_act == $past(shadow_q)));
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_en && !upd_evt) |=> $stable(cmp_act));
    a_r10_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !shadow_en) |=> (cmp_act == $past(wdata)));
    a_r10_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (!shadow_en && !wr) |=> $stable(cmp_act));

endmodule

// File: rtl/tcc_mode_reg.sv
// Mode register with a write lock.
// Assumes the lock is a level: while prot_lvl is LOCK_FULL every write is dropped.
module tcc_mode_reg
    import tcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [2:0] wdata,
    input  logic [1:0] prot_lvl,
    output cmp_mode_e  mode
);

    logic locked;

    // Lock decode.
    always_comb locked = (prot_lvl == LOCK_FULL);

    // Mode capture when not locked; resets to hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MD_HOLD;
        else if (wr && !locked)
            mode <= cmp_mode_e'(wdata);
    end

    a_r12_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && prot_lvl == 2'b11) |=> $stable(mode));
    a_r12_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && prot_lvl != 2'b11) |=> (mode == $past(wdata)));

endmodule

// File: rtl/tcc_ref_gen.sv
// Reference level generator for one compare channel.
// Assumes cmp_act and mode are registered upstream. Output is registered, so
// each decision takes effect one clock after the inputs that caused it.
// Match modes act on arrival (equal now, not equal the cycle before). The
// pulse-width modes refresh only on entry from hold or when the raw compare
// result changes. The trigger clear overrides every mode.
module tcc_ref_gen
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic [CNT_W-1:0] cmp_act,
    input  cmp_mode_e        mode,
    input  logic             clr_en,
    input  logic             ext_trig,
    output logic             ref_q
);

    logic      match_now, match_d, hit;
    logic      cmp_res, res_d, refresh, clear_now;
    cmp_mode_e mode_d;
    logic      ref_nxt;

    // Compare decode: arrival detection, raw result, refresh and clear.
    always_comb begin
        match_now = (cnt_val == cmp_act);
        hit       = match_now && !match_d;
        cmp_res   = cnt_down ? (cnt_val <= cmp_act) : (cnt_val < cmp_act);
        refresh   = (mode_d == MD_HOLD) || (cmp_res != res_d);
        clear_now = clr_en && ext_trig;
    end

    // Next reference level by mode, with the trigger clear on top.
    always_comb begin
        ref_nxt = ref_q;
        if (clear_now) begin
            ref_nxt = 1'b0;
        end else begin
            unique case (mode)
                MD_HOLD:  ref_nxt = ref_q;
                MD_SET:   if (hit) ref_nxt = 1'b1;
                MD_CLR:   if (hit) ref_nxt = 1'b0;
                MD_TGL:   if (hit) ref_nxt = !ref_q;
                MD_LOW:   ref_nxt = 1'b0;
                MD_HIGH:  ref_nxt = 1'b1;
                MD_PWM_A: if (refresh) ref_nxt = cmp_res;
                MD_PWM_B: if (refresh) ref_nxt = !cmp_res;
                default:  ref_nxt = ref_q;
            endcase
        end
    end

    // State: reference, previous match, previous result, previous mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= 1'b0;
            match_d <= 1'b0;
            res_d   <= 1'b0;
            mode_d  <= MD_HOLD;
        end else begin
            ref_q   <= ref_nxt;
            match_d <= match_now;
            res_d   <= cmp_res;
            mode_d  <= mode;
        end
    end

    a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_HOLD && !(clr_en && ext_trig)) |=> $stable(ref_q));
    a_r2_set_on_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_SET && !clear_now && match_now && !match_d) |=> ref_q);
    a_r2_set_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_SET && !clear_now) |=> !$fell(ref_q));
    a_r2_clr_on_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_CLR && !clear_now && match_now && !match_d) |=> !ref_q);
    a_r3_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_TGL && !clear_now && match_now && !match_d) |=> (ref_q != $past(ref_q)));
    a_r3_toggle_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_TGL && !clear_now && match_now && match_d) |=> $stable(ref_q));
    a_r4_force_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_LOW) |=> !ref_q);
    a_r4_force_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_HIGH && !clear_now) |=> ref_q);
    a_r5_pwm0_up: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_PWM_A && !cnt_down && cnt_val < cmp_act && !clear_now && refresh) |=> ref_q);
    a_r5_pwm0_down: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_PWM_A && cnt_down && cnt_val > cmp_act && !clear_now && refresh) |=> !ref_q);
    a_r6_pwm1_up: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_PWM_B && !cnt_down && cnt_val < cmp_act && !clear_now && refresh) |=> !ref_q);
    a_r6_pwm1_down: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_PWM_B && cnt_down && cnt_val > cmp_act && !clear_now && refresh) |=> ref_q);
    a_r7_pwm_no_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MD_PWM_A || mode == MD_PWM_B) && !clear_now && !refresh) |=> $stable(ref_q));
    a_r8_trigger_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && ext_trig) |=> !ref_q);

endmodule

// File: rtl/tmr_cmp_channel.sv
// Top of one timer output compare channel: compare storage, mode register,
// reference generator and pin polarity.
// Assumes the counter, direction and update pulse come from a timer in the
// same clock domain.
module tmr_cmp_channel
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic             upd_evt,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             shadow_en,
    input  logic             mode_wr,
    input  logic [2:0]       mode_wdata,
    input  logic [1:0]       prot_lvl,
    input  logic             clr_en,
    input  logic             ext_trig,
    input  logic             polarity,
    output logic             ref_o,
    output logic             pin_o
);

    logic [CNT_W-1:0] cmp_act;
    cmp_mode_e        mode;

    tcc_cmp_store #(.CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cmp_wr),
        .wdata    (cmp_wdata),
        .shadow_en(shadow_en),
        .upd_evt  (upd_evt),
        .cmp_act  (cmp_act)
    );

    tcc_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (mode_wr),
        .wdata   (mode_wdata),
        .prot_lvl(prot_lvl),
        .mode    (mode)
    );

    tcc_ref_gen #(.CNT_W(CNT_W)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_val (cnt_val),
        .cnt_down(cnt_down),
        .cmp_act (cmp_act),
        .mode    (mode),
        .clr_en  (clr_en),
        .ext_trig(ext_trig),
        .ref_q   (ref_o)
    );

    // Pin level: reference with the output polarity applied.
    always_comb pin_o = ref_o ^ polarity;

    // R11: pin follows reference and polarity.
    always_comb begin
        if (rst_n) a_r11_pin_polarity: assert (pin_o == (ref_o != polarity));
    end

endmodule

// File: tb/tmr_cmp_channel_test.sv
`timescale 1ns/100ps
module tmr_cmp_channel_test;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic         cnt_down = 1'b0;
    logic         upd_evt = 1'b0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         shadow_en = 1'b0;
    logic         mode_wr = 1'b0;
    logic [2:0]   mode_wdata = 3'd0;
    logic [1:0]   prot_lvl = 2'b00;
    logic         clr_en = 1'b0;
    logic         ext_trig = 1'b0;
    logic         polarity = 1'b0;
    logic         ref_o, pin_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    tmr_cmp_channel #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
        .upd_evt(upd_evt), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .shadow_en(shadow_en), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .prot_lvl(prot_lvl), .clr_en(clr_en), .ext_trig(ext_trig),
        .polarity(polarity), .ref_o(ref_o), .pin_o(pin_o)
    );

    always #2.5 clk = ~clk;

    // One clock: returns at the falling edge after the next rising edge.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input logic got, input logic exp, input string tag);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // Mode write, then one more clock so the reference reflects the new mode.
    task automatic set_mode(input logic [2:0] m);
        mode_wr = 1'b1; mode_wdata = m;
        tick();
        mode_wr = 1'b0;
        tick();
    endtask

    task automatic set_cmp(input logic [W-1:0] v);
        shadow_en = 1'b0; cmp_wr = 1'b1; cmp_wdata = v;
        tick();
        cmp_wr = 1'b0;
    endtask

    function automatic logic pwm_lvl(input int c, input int k, input logic dn, input logic inv);
        logic r;
        r = dn ? (c <= k) : (c < k);
        return r ^ inv;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic         exp;
        logic [W-1:0] park;
        int           cmpv, prev;
        logic         hit;

        // R13: reset state
        tick(); tick();
        chk(ref_o, 1'b0, "R13 ref in reset");
        rst_n = 1'b1;
        tick(); tick();
        chk(ref_o, 1'b0, "R13 ref after reset");
        chk(pin_o, 1'b0, "R13 pin after reset");

        // R11: polarity
        polarity = 1'b1; #1;
        chk(pin_o, 1'b1, "R11 pin inverted, ref 0");
        set_mode(3'b101);
        chk(pin_o, 1'b0, "R11 pin inverted, ref 1");
        polarity = 1'b0; #1;
        chk(pin_o, 1'b1, "R11 pin plain, ref 1");

        // R1: hold keeps either level while the counter passes the compare value
        set_cmp(4'd6);
        for (int lv = 1; lv >= 0; lv--) begin
            cnt_val = 4'd15;
            set_mode(lv ? 3'b101 : 3'b100);
            set_mode(3'b000);
            for (int c = 0; c < 16; c++) begin
                cnt_val = 4'(c); tick();
                chk(ref_o, 1'(lv), "R1 hold");
            end
        end

        // R2/R3/R4: match modes over the full counter range, each value held two clocks
        for (int mi = 1; mi <= 3; mi++) begin
            for (int ci = 0; ci < 3; ci++) begin
                cmpv = (ci == 0) ? 0 : (ci == 1) ? 6 : 15;
                park = (cmpv == 15) ? 4'd0 : 4'd15;
                cnt_val = park;
                exp = (mi == 2);
                set_mode(mi == 2 ? 3'b101 : 3'b100);
                chk(ref_o, exp, "R4 forced start level");
                set_cmp(4'(cmpv));
                set_mode(3'(mi));
                chk(ref_o, exp, mi == 3 ? "R3 no toggle before arrival" : "R2 no action before arrival");
                prev = int'(park);
                for (int pass = 0; pass < 2; pass++) begin
                    for (int i = 0; i < 32; i++) begin
                        cnt_val = 4'(i / 2);
                        tick();
                        hit = ((i / 2) == cmpv) && (prev != cmpv);
                        if (hit) begin
                            if (mi == 1) exp = 1'b1;
                            else if (mi == 2) exp = 1'b0;
                            else exp = !exp;
                        end
                        chk(ref_o, exp, mi == 3 ? "R3 toggle once per arrival" : "R2 set/clear on arrival");
                        prev = i / 2;
                    end
                end
            end
        end

        // R5/R6: both pulse-width modes, both directions, every compare and counter value
        for (int m = 6; m <= 7; m++) begin
            set_mode(3'b000);
            set_mode(3'(m));
            for (int d = 0; d < 2; d++) begin
                cnt_down = 1'(d);
                for (int k = 0; k < 16; k++) begin
                    set_cmp(4'(k));
                    for (int c = 0; c < 16; c++) begin
                        cnt_val = 4'(c); tick();
                        chk(ref_o, pwm_lvl(c, k, 1'(d), 1'(m - 6)), m == 6 ? "R5 pwm mode 0" : "R6 pwm mode 1");
                    end
                end
            end
        end
        cnt_down = 1'b0;

        // R7: entry from a forced level with an unchanged result keeps the level
        set_cmp(4'd4); cnt_val = 4'd10;
        set_mode(3'b101);
        set_mode(3'b110);
        tick();
        chk(ref_o, 1'b1, "R7 no refresh entering from force high");
        cnt_val = 4'd2; tick();
        chk(ref_o, 1'b1, "R7 refresh on result change");
        cnt_val = 4'd10; tick();
        chk(ref_o, 1'b0, "R7 follows result");
        set_mode(3'b111); tick();
        chk(ref_o, 1'b0, "R7 mode 0 to mode 1 without result change holds");
        // entry from hold always refreshes
        set_mode(3'b101);
        set_mode(3'b000);
        set_mode(3'b110);
        chk(ref_o, 1'b0, "R7 refresh on entry from hold");

        // R8: trigger clear
        cnt_val = 4'd2; tick();
        chk(ref_o, 1'b1, "R8 pwm level before trigger");
        clr_en = 1'b1; ext_trig = 1'b1; tick();
        chk(ref_o, 1'b0, "R8 trigger clears pwm");
        ext_trig = 1'b0; tick(); tick();
        chk(ref_o, 1'b0, "R8 clear persists without result change");
        cnt_val = 4'd10; tick();
        cnt_val = 4'd1; tick();
        chk(ref_o, 1'b1, "R8 pwm resumes on result change");
        ext_trig = 1'b1;
        set_mode(3'b101);
        chk(ref_o, 1'b0, "R8 clear beats force high");
        clr_en = 1'b0; tick();
        chk(ref_o, 1'b1, "R8 trigger ignored when disabled");
        ext_trig = 1'b0;

        // R9/R10: shadowed and direct compare writes
        set_mode(3'b000);
        cnt_val = 4'd5;
        set_cmp(4'd3);
        set_mode(3'b110);
        chk(ref_o, 1'b0, "R10 direct compare 3");
        shadow_en = 1'b1; cmp_wr = 1'b1; cmp_wdata = 4'd9; tick();
        cmp_wr = 1'b0; tick(); tick();
        chk(ref_o, 1'b0, "R9 shadow write not yet active");
        upd_evt = 1'b1; tick();
        upd_evt = 1'b0; tick();
        chk(ref_o, 1'b1, "R9 shadow moved on update");
        set_cmp(4'd2); tick();
        chk(ref_o, 1'b0, "R10 direct write takes effect");
        upd_evt = 1'b1; tick();
        upd_evt = 1'b0; tick();
        chk(ref_o, 1'b0, "R10 update ignored without shadowing");

        // R12: protection lock
        set_mode(3'b100);
        prot_lvl = 2'b11;
        set_mode(3'b101);
        chk(ref_o, 1'b0, "R12 locked mode write ignored");
        prot_lvl = 2'b10;
        set_mode(3'b101);
        chk(ref_o, 1'b1, "R12 unlocked mode write lands");
        prot_lvl = 2'b00;

        // R13: reset mid-run returns to hold with reference 0
        rst_n = 1'b0; tick();
        rst_n = 1'b1; tick(); tick();
        chk(ref_o, 1'b0, "R13 reference after mid-run reset");
        cnt_val = 4'd0; tick(); tick();
        chk(ref_o, 1'b0, "R13 mode back to hold");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule